// File: doc/BRIEF.md
# PPS-Aligned Block Sequence Source

This block produces a framed stream of fixed-length blocks on the sample clock. Each block is marked by a start strobe (`out_sop`) and an end strobe (`out_eop`). It carries a block sequence number and may carry a sync flag. A sync marks the first block whose reference start lies at or after a pulse-per-second event. When that pulse falls inside a block, the sync is held pending and placed on the next block start. This keeps the block grid tied to a global seconds grid.

The stream can start in two ways. An immediate start begins streaming on the clock after the enable is sampled high. A PPS-aligned start arms on the enable and waits for the next PPS. It then waits a programmable offset in clocks and issues its first block with a preloaded sequence number.

The correct preload values follow from the PPS index `s`:
- `init = ceil(s * CLK_PER_PPS / BLK_LEN)`
- `offset = init * BLK_LEN - s * CLK_PER_PPS`

With these values the output grid matches the ideal grid that starts at PPS 0, delayed by a fixed three clocks. The generator is time-driven and cannot stall, so the output stream has no ready input and accepts no back-pressure. A downstream consumer must take every beat while `out_valid` is high.

Top module: `pps_block_source`

## Requirements
- R1: `out_sop` is high on the first clock of a block and `out_eop` exactly BLK_LEN-1 clocks later. `out_valid` is high on every clock from sop to eop. A new sop follows an eop at the earliest on the next clock.
- R2: The first block of every run carries the value of `bsn_init` that is sampled when the run starts. Each following block in the same run carries the previous number plus one, modulo 2^BSN_W.
- R3: `out_sync` is high only together with `out_sop`. Take a block start observed after rising edge B, and let Bp be the edge of the previous block start since reset, from any run. The block carries sync exactly when `pps` was sampled high at some edge t with Bp-2 < t <= B-2. A PPS that coincides with the ideal block start therefore syncs that same block, and a PPS that falls later is held for the next block.
- R4: With `en` and `pps_mode` high, the block arms. Take the first PPS sampled at edge t after arming, at least two edges after the enable edge. `bsn_ofs` is captured, and the first sop is observed after edge t+2+`bsn_ofs`. This is three clocks of latency for an offset of zero. `bsn_ofs` is ceil(log2(BLK_LEN)) bits wide.
- R5: With `en` high and `pps_mode` low in the idle state, the first sop is observed after the same edge that samples `en` high.
- R6: Take `en` sampled low at edge E during a run. Streaming ends with the first eop observed after an edge at or beyond E-1, and `out_valid` is low from the following clock. No partial block is ever emitted.
- R7: A PPS sampled while idle, or one that arrives after the armed enable was dropped, starts no block. Dropping `en` while armed or while the offset counts returns the block to idle.
- R8: `status` equals `out_valid`. `restart` is high for one clock, on the first sop of each run only.
- R9: While `rst_n` is low, `out_valid`, `out_sop`, `out_eop`, `out_sync`, `restart` and `status` are low, and any pending sync is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | One-clock pulse per second |
| en | input | 1 | Run enable; low stops the stream at the next block end |
| pps_mode | input | 1 | 1: arm and wait for PPS plus offset; 0: start at once |
| bsn_init | input | BSN_W | Sequence number of the first block of a run |
| bsn_ofs | input | OFS_W | Clocks from the arming PPS to the first block start |
| out_valid | output | 1 | Stream beat valid (no back-pressure) |
| out_sop | output | 1 | First beat of a block |
| out_eop | output | 1 | Last beat of a block |
| out_bsn | output | BSN_W | Sequence number of the current block |
| out_sync | output | 1 | Block start that follows a PPS |
| status | output | 1 | Stream running |
| restart | output | 1 | First sop of a run |

## Verification
Two things can coincide in the same cycle. The first is a PPS that lands on a block's ideal start: the pending-sync flag is cleared by that start while the same pulse sets it. The second is a stop request that falls on the eop decision edge.

The bench provokes both cases through several PPS-aligned starts at seven consecutive seconds residues. Together these cover every offset from 0 to 6 and place the PPS at every phase of the block. It also drops the enable on the very clock of an eop.

Each sop's sync is judged arithmetically against the window of PPS edges since the previous block start. The stop cycle is computed from the run's start and the drop cycle.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // run-control states
  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_ARMED = 2'd1,
    CT_DELAY = 2'd2,
    CT_RUN   = 2'd3
  } ctl_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pbs_pps_track.sv
module pbs_pps_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pps,
  input  logic blk_start,
  output logic pps_seen,
  output logic sync_out
);

  logic pend;

  // PPS register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pps_seen <= 1'b0;
    else        pps_seen <= pps;
  end

  // pending sync: a fresh PPS wins over the clear by a block start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pps_seen) begin
      pend <= 1'b1;
    end else if (blk_start) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= blk_start & pend;
  end

endmodule

// File: rtl/pbs_start_ctl.sv
module pbs_start_ctl
  import pbs_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pps_mode,
  input  logic             pps_seen,
  input  logic [OFS_W-1:0] ofs,
  input  logic             blk_last,
  output logic             blk_start,
  output logic             blk_first
);

  ctl_state_e       state, state_nxt;
  logic [OFS_W-1:0] ofs_cnt, ofs_cnt_nxt;

  always_comb begin
    state_nxt   = state;
    ofs_cnt_nxt = ofs_cnt;
    blk_start   = 1'b0;
    blk_first   = 1'b0;
    unique case (state)
      CT_IDLE: begin
        if (en) begin
          if (pps_mode) begin
            state_nxt = CT_ARMED;
          end else begin
            blk_start = 1'b1;
            blk_first = 1'b1;
            state_nxt = CT_RUN;
          end
        end
      end
      CT_ARMED: begin
        if (!en) begin
          state_nxt = CT_IDLE;
        end else if (pps_seen) begin
          ofs_cnt_nxt = ofs;
          state_nxt   = CT_DELAY;
        end
      end
      CT_DELAY: begin
        if (!en) begin
          state_nxt = CT_IDLE;
        end else if (ofs_cnt == '0) begin
          blk_start = 1'b1;
          blk_first = 1'b1;
          state_nxt = CT_RUN;
        end else begin
          ofs_cnt_nxt = ofs_cnt - OFS_W'(1);
        end
      end
      CT_RUN: begin
        if (blk_last) begin
          if (en) blk_start = 1'b1;
          else    state_nxt = CT_IDLE;
        end
      end
      default: state_nxt = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CT_IDLE;
      ofs_cnt <= '0;
    end else begin
      state   <= state_nxt;
      ofs_cnt <= ofs_cnt_nxt;
    end
  end

endmodule

// File: rtl/pbs_framer.sv
module pbs_framer
  import pbs_pkg::*;
#(
  parameter int BLK_LEN = 7,
  parameter int BSN_W   = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             blk_first,
  input  logic [BSN_W-1:0] bsn_init,
  output logic             valid,
  output logic             sop,
  output logic             eop,
  output logic [BSN_W-1:0] bsn,
  output logic             restart
);

  localparam int unsigned POS_W = cnt_width(BLK_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_LEN - 1);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pos   <= '0;
    end else if (blk_start) begin
      valid <= 1'b1;
      pos   <= '0;
    end else if (valid && pos == POS_LAST) begin
      valid <= 1'b0;
      pos   <= '0;
    end else if (valid) begin
      pos   <= pos + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsn <= '0;
    end else if (blk_start) begin
      bsn <= blk_first ? bsn_init : bsn + BSN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop     <= 1'b0;
      restart <= 1'b0;
    end else begin
      sop     <= blk_start;
      restart <= blk_start & blk_first;
    end
  end

  assign eop = valid && (pos == POS_LAST);

endmodule

// File: rtl/pps_block_source.sv
module pps_block_source
  import pbs_pkg::*;
#(
  parameter int BLK_LEN     = 7,
  parameter int CLK_PER_PPS = 10,
  parameter int BSN_W       = 31,
  localparam int OFS_W      = cnt_width(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps,
  input  logic             en,
  input  logic             pps_mode,
  input  logic [BSN_W-1:0] bsn_init,
  input  logic [OFS_W-1:0] bsn_ofs,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic [BSN_W-1:0] out_bsn,
  output logic             out_sync,
  output logic             status,
  output logic             restart
);

  logic pps_seen;
  logic blk_start;
  logic blk_first;

  pbs_pps_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps       (pps),
    .blk_start (blk_start),
    .pps_seen  (pps_seen),
    .sync_out  (out_sync)
  );

  pbs_start_ctl #(.OFS_W(OFS_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pps_mode  (pps_mode),
    .pps_seen  (pps_seen),
    .ofs       (bsn_ofs),
    .blk_last  (out_eop),
    .blk_start (blk_start),
    .blk_first (blk_first)
  );

  pbs_framer #(.BLK_LEN(BLK_LEN), .BSN_W(BSN_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .blk_first (blk_first),
    .bsn_init  (bsn_init),
    .valid     (out_valid),
    .sop       (out_sop),
    .eop       (out_eop),
    .bsn       (out_bsn),
    .restart   (restart)
  );

  assign status = out_valid;

endmodule

// File: rtl/pbs_chk.sv
module pbs_chk
  import pbs_pkg::*;
#(
  parameter int BLK_LEN     = 7,
  parameter int CLK_PER_PPS = 10,
  parameter int BSN_W       = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             sop,
  input logic             eop,
  input logic             sync,
  input logic             restart,
  input logic             status,
  input logic [BSN_W-1:0] bsn
);

  localparam int unsigned BC_W  = cnt_width(BLK_LEN) + 1;
  localparam int unsigned GAP_W = cnt_width(CLK_PER_PPS + BLK_LEN) + 1;

  logic [BC_W-1:0]  beat;
  logic [GAP_W-1:0] gap;
  logic [BSN_W-1:0] last_bsn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat     <= '0;
      gap      <= '0;
      last_bsn <= '0;
    end else begin
      beat <= sop ? BC_W'(1) : (valid ? beat + BC_W'(1) : '0);
      gap  <= (sync || !valid) ? '0 : gap + GAP_W'(1);
      if (sop) last_bsn <= bsn;
    end
  end

  // R1
  eop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop) |-> (beat == BC_W'(BLK_LEN - 1)));
  // R1
  sop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && $past(valid)) |-> $past(eop));
  // R6
  no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !eop) |=> valid);
  // R2
  bsn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && !restart) |-> (bsn == last_bsn + BSN_W'(1)));
  // R3
  sync_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> sop);
  // R3 (holds while PPS arrives every CLK_PER_PPS clocks)
  sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (gap < GAP_W'(CLK_PER_PPS + BLK_LEN)));
  // R8
  restart_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (sop && status));
  // R8
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> restart);

endmodule

bind pps_block_source pbs_chk #(
  .BLK_LEN(BLK_LEN), .CLK_PER_PPS(CLK_PER_PPS), .BSN_W(BSN_W)
) u_pbs_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid   (out_valid),
  .sop     (out_sop),
  .eop     (out_eop),
  .sync    (out_sync),
  .restart (restart),
  .status  (status),
  .bsn     (out_bsn)
);

// File: tb/tb_pps_block_source.sv
`timescale 1ns/1ps
module tb_pps_block_source;

  localparam int BL    = 7;
  localparam int PER   = 10;
  localparam int BW    = 31;
  localparam int OW    = (BL > 1) ? $clog2(BL) : 1;
  localparam int P0    = 20;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps = 1'b0;
  logic en = 1'b0;
  logic pps_mode = 1'b0;
  logic [BW-1:0] bsn_init = '0;
  logic [OW-1:0] bsn_ofs = '0;
  logic out_valid, out_sop, out_eop, out_sync, status, restart;
  logic [BW-1:0] out_bsn;

  int cur = -1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // expected run window, written by the stimulus
  bit have_run = 1'b0;
  int run_s = 0;
  int run_end = NEVER;
  int run_init = 0;
  int prev_sop = -1000;

  always #4 clk = ~clk;

  pps_block_source #(.BLK_LEN(BL), .CLK_PER_PPS(PER), .BSN_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pps(pps), .en(en), .pps_mode(pps_mode),
    .bsn_init(bsn_init), .bsn_ofs(bsn_ofs),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_bsn(out_bsn), .out_sync(out_sync), .status(status), .restart(restart)
  );

  always @(posedge clk) cur <= cur + 1;

  // periodic PPS, high for the edge index P0 + k*PER
  always @(posedge clk) begin
    #2;
    pps = (cur + 1 >= P0) && (((cur + 1 - P0) % PER) == 0);
  end

  function automatic bit pps_between(input int lo, input int hi);
    int kmax;
    if (hi < P0) return 1'b0;
    kmax = (hi - P0) / PER;
    if (lo < P0) return 1'b1;
    return kmax > ((lo - P0) / PER);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, cur, act, exp);
    end
  endtask

  // per-cycle comparison against the arithmetic model
  always @(negedge clk) begin
    if (cur >= 0 && !done) begin
      bit in_run, e_sop, e_eop, e_sync;
      int ph;
      in_run = have_run && cur >= run_s && cur <= run_end;
      ph     = in_run ? (cur - run_s) % BL : 0;
      e_sop  = in_run && ph == 0;
      e_eop  = in_run && ph == BL - 1;
      e_sync = e_sop && pps_between(prev_sop - 2, cur - 2);
      if (!rst_n) begin
        chk(!out_valid && !out_sop && !out_eop && !out_sync && !restart && !status,
            "R9", "reset outputs", {out_valid, out_sop, out_eop, out_sync, restart, status}, 0);
      end else begin
        chk(out_valid == in_run, "R6", "valid", out_valid, in_run);
        chk(out_sop == e_sop, "R1", "sop", out_sop, e_sop);
        chk(out_eop == e_eop, "R1", "eop", out_eop, e_eop);
        chk(out_sync == e_sync, "R3", "sync", out_sync, e_sync);
        chk(status == in_run, "R8", "status", status, in_run);
        chk(restart == (in_run && cur == run_s), "R8", "restart", restart, in_run && cur == run_s);
        if (in_run)
          chk(out_bsn == BW'(run_init + (cur - run_s) / BL), "R2", "bsn",
              out_bsn, run_init + (cur - run_s) / BL);
      end
      if (e_sop) prev_sop = cur;
    end
  end

  task automatic wait_to(input int last_edge);
    do begin
      @(posedge clk);
      #2;
    end while (cur < last_edge);
  endtask

  // drop en after edge L; the run ends at the first eop observed at or after L (R6)
  task automatic stop_at(input int last_edge);
    int ce;
    wait_to(last_edge);
    en = 1'b0;
    ce = run_s + BL - 1;
    while (ce < last_edge) ce += BL;
    run_end = ce;
  endtask

  // immediate start: en sampled at edge L+1, first sop observed there (R5)
  task automatic run_now(input int init, input int last_edge, input int len);
    wait_to(last_edge);
    bsn_init = BW'(init);
    pps_mode = 1'b0;
    en       = 1'b1;
    run_init = init;
    run_s    = last_edge + 1;
    run_end  = NEVER;
    have_run = 1'b1;
    stop_at(last_edge + 1 + len);
  endtask

  // aligned start on PPS number s (R4): offset and number from the seconds grid
  task automatic run_pps(input int s, input int len);
    int t, init, off;
    t    = P0 + PER * s;
    init = (PER * s + BL - 1) / BL;
    off  = init * BL - PER * s;
    wait_to(t - 3);
    bsn_init = BW'(init);
    bsn_ofs  = OW'(off);
    pps_mode = 1'b1;
    en       = 1'b1;
    run_init = init;
    run_s    = t + 2 + off;
    run_end  = NEVER;
    have_run = 1'b1;
    // R4: the grid lines up with block number init on the global grid
    chk(run_s == P0 + 2 + BL * init, "R4", "grid start", run_s, P0 + 2 + BL * init);
    stop_at(t + len);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait_to(4);
    rst_n = 1'b1;
    // immediate start, a PPS already pending (R5, R2, R3)
    run_now(1000, 40, 30);
    // aligned starts sweeping every offset value 0..6 (R4, R3)
    for (int j = 0; j < 7; j++) run_pps(7 + 5 * j, 35);
    // arm, then drop en before the PPS: nothing starts (R7)
    wait_to(P0 + PER * 42 - 3);
    pps_mode = 1'b1;
    en = 1'b1;
    wait_to(P0 + PER * 42 - 2);
    en = 1'b0;
    // immediate start whose stop lands on an eop edge (R5, R6, R3)
    run_now(77, 460, 20);
    // PPS while idle: silence checked per cycle (R7)
    wait_to(540);
    // immediate start with bsn wrap at the top of the range (R2)
    run_now((1 << BW) - 2, 545, 25);
    wait_to(600);
    finish_up();
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

endmodule